// File: doc/BRIEF.md
# Watchdog Frequency Fall-Back Sequencer

This block decides which 5-bit frequency code drives a programmable clock generator, and it gets the system running again when software stops responding. The code comes from one of three places. The first is a software frequency setting that the block holds. The second is a fall-back code supplied by the register file. The third is a strap-jumper code read from board pins, which is the source of last resort. A slow timebase tick paces the watchdog counter and the width of the reset pulse.

Once software enables the watchdog, it must pulse the service strobe before the timeout runs out. If it does not, the block drives a long active-low system reset. It also moves one step along the recovery ladder: from the software code to the fall-back code, and from the fall-back code to the strap code. On every recovery the enable bit is cleared and the fall-back code is copied into the software setting. The block returns to the software code only after software has rewritten the code and then enabled the watchdog again.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `wdt_freq_recovery`

## Requirements
- R1: After reset, the selected code follows the strap pins, the reset output is high, the enable bit is 0 and the held software code is 0.
- R2: With the watchdog enabled and no service, the reset output goes low on the TIMEOUT_TICKS-th tick after the enable write, and it stays low for exactly PULSE_TICKS ticks.
- R3: A service strobe restarts the timeout count from zero and leaves the selected code unchanged.
- R4: While the enable bit is 0, no reset pulse is produced, however long the wait.
- R5: A timeout while the software code is in use makes the fall-back code the selection after the pulse. It also copies the fall-back code into the software setting and clears the enable bit.
- R6: A timeout while the fall-back code is in use makes the strap code the selection after the pulse, with the same copy and clear.
- R7: The selected code holds steady for the whole low pulse. The new code appears on the same clock edge at which the reset output returns high.
- R8: Writing the enable bit alone does not leave the fall-back or strap source. A code write followed by an enable write of 1 returns the selection to the software code.
- R9: Code and enable writes made while the reset output is low are ignored.
- R10: Clock cycles without a tick do not advance the timeout count.
- R11: A timeout while the strap code is in use keeps the strap code and issues another pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow timebase strobe, one clock wide |
| svc | input | 1 | Watchdog service strobe |
| cfg_code_we | input | 1 | Write strobe for the software frequency code |
| cfg_code_d | input | CODE_W | Software frequency code to write |
| cfg_en_we | input | 1 | Write strobe for the watchdog enable bit |
| cfg_en_d | input | 1 | Enable value to write |
| fb_code | input | CODE_W | Fall-back frequency code from the register file |
| strap_code | input | CODE_W | Strap-jumper frequency code |
| sel_code | output | CODE_W | Active frequency code |
| sys_rst_n | output | 1 | Active-low system reset pulse |
| cfg_code | output | CODE_W | Held software frequency code |
| cfg_wd_en | output | 1 | Held watchdog enable bit |

## Verification
The bench builds the block with TIMEOUT_TICKS = 8 and PULSE_TICKS = 5. With these values, full timeouts and complete reset pulses fit into a few dozen cycles, so the bench can count their exact cycle length at the ports. The short values also leave room to walk the whole escalation ladder repeatedly with different code sets. They make it cheap to run the service-just-in-time, tick-starved and write-during-pulse cases as well.

// File: rtl/wfr_pkg.sv
package wfr_pkg;
  typedef enum logic [1:0] {
    SRC_SW       = 2'd0,
    SRC_FALLBACK = 2'd1,
    SRC_STRAP    = 2'd2
  } src_e;
endpackage

// File: rtl/wfr_wd_timer.sv
module wfr_wd_timer #(
  parameter int TIMEOUT_TICKS = 2000,
  localparam int CW = (TIMEOUT_TICKS > 2) ? $clog2(TIMEOUT_TICKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic wd_en,
  input  logic svc,
  input  logic hold,
  output logic timeout
);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

  logic [CW-1:0] cnt;

  assign timeout = wd_en && !hold && !svc && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!wd_en || svc || hold || timeout) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_timeout_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> wd_en);
  assert_service_blocks_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> !timeout);
  assert_tick_paces_timeout_R10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> tick);
endmodule

// File: rtl/wfr_pulse_gen.sv
module wfr_pulse_gen #(
  parameter int PULSE_TICKS = 500,
  localparam int CW = (PULSE_TICKS > 2) ? $clog2(PULSE_TICKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  output logic active,
  output logic done
);
  localparam logic [CW-1:0] LAST = CW'(PULSE_TICKS - 1);

  logic [CW-1:0] cnt;

  assign done = active && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (done) begin
      active <= 1'b0;
    end else if (active && tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_start_opens_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active);
  assert_pulse_ends_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(tick));
endmodule

// File: rtl/wfr_esc_ctrl.sv
module wfr_esc_ctrl
  import wfr_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              timeout,
  input  logic              pulse_active,
  input  logic              pulse_done,
  input  logic              code_we,
  input  logic [CODE_W-1:0] code_d,
  input  logic              en_we,
  input  logic              en_d,
  input  logic [CODE_W-1:0] fb_code,
  input  logic [CODE_W-1:0] strap_code,
  output logic [CODE_W-1:0] cfg_code_q,
  output logic              cfg_en_q,
  output logic [CODE_W-1:0] sel_q
);
  src_e              src_q;
  src_e              src_next_esc;
  logic              rewritten_q;
  logic [CODE_W-1:0] sel_mux;

  always_comb begin
    unique case (src_q)
      SRC_SW:       src_next_esc = SRC_FALLBACK;
      SRC_FALLBACK: src_next_esc = SRC_STRAP;
      default:      src_next_esc = SRC_STRAP;
    endcase
  end

  always_comb begin
    unique case (src_q)
      SRC_SW:       sel_mux = cfg_code_q;
      SRC_FALLBACK: sel_mux = fb_code;
      default:      sel_mux = strap_code;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q       <= SRC_STRAP;
      cfg_code_q  <= '0;
      cfg_en_q    <= 1'b0;
      rewritten_q <= 1'b0;
    end else if (timeout) begin
      src_q       <= src_next_esc;
      cfg_code_q  <= fb_code;
      cfg_en_q    <= 1'b0;
      rewritten_q <= 1'b0;
    end else if (!pulse_active) begin
      if (code_we) begin
        cfg_code_q  <= code_d;
        rewritten_q <= 1'b1;
      end
      if (en_we) begin
        cfg_en_q <= en_d;
        if (en_d && (rewritten_q || code_we)) begin
          src_q       <= SRC_SW;
          rewritten_q <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (!pulse_active || pulse_done) begin
      sel_q <= sel_mux;
    end
  end

  assert_recovery_clears_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !cfg_en_q);
  assert_first_step_fallback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && src_q == SRC_SW) |=> src_q == SRC_FALLBACK);
  assert_second_step_strap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && src_q != SRC_SW) |=> src_q == SRC_STRAP);
  assert_writes_blocked_in_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_active && !timeout) |=> ($stable(cfg_code_q) && $stable(cfg_en_q)));
  assert_sel_frozen_in_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_active && !pulse_done) |=> $stable(sel_q));
endmodule

// File: rtl/wdt_freq_recovery.sv
module wdt_freq_recovery #(
  parameter int CODE_W        = 5,
  parameter int TIMEOUT_TICKS = 2000,
  parameter int PULSE_TICKS   = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              svc,
  input  logic              cfg_code_we,
  input  logic [CODE_W-1:0] cfg_code_d,
  input  logic              cfg_en_we,
  input  logic              cfg_en_d,
  input  logic [CODE_W-1:0] fb_code,
  input  logic [CODE_W-1:0] strap_code,
  output logic [CODE_W-1:0] sel_code,
  output logic              sys_rst_n,
  output logic [CODE_W-1:0] cfg_code,
  output logic              cfg_wd_en
);
  logic timeout;
  logic pulse_active;
  logic pulse_done;

  wfr_wd_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wd_en   (cfg_wd_en),
    .svc     (svc),
    .hold    (pulse_active),
    .timeout (timeout)
  );

  wfr_pulse_gen #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .start  (timeout),
    .active (pulse_active),
    .done   (pulse_done)
  );

  wfr_esc_ctrl #(.CODE_W(CODE_W)) u_esc (
    .clk          (clk),
    .rst_n        (rst_n),
    .timeout      (timeout),
    .pulse_active (pulse_active),
    .pulse_done   (pulse_done),
    .code_we      (cfg_code_we),
    .code_d       (cfg_code_d),
    .en_we        (cfg_en_we),
    .en_d         (cfg_en_d),
    .fb_code      (fb_code),
    .strap_code   (strap_code),
    .cfg_code_q   (cfg_code),
    .cfg_en_q     (cfg_wd_en),
    .sel_q        (sel_code)
  );

  assign sys_rst_n = !pulse_active;

  assert_no_pulse_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sys_rst_n)) |-> $past(cfg_wd_en));
endmodule

// File: tb/tb_wdt_freq_recovery.sv
module tb_wdt_freq_recovery;
  localparam int CW = 5;
  localparam int T  = 8;
  localparam int P  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic svc = 1'b0;
  logic cfg_code_we = 1'b0;
  logic [CW-1:0] cfg_code_d = '0;
  logic cfg_en_we = 1'b0;
  logic cfg_en_d = 1'b0;
  logic [CW-1:0] fb_code = '0;
  logic [CW-1:0] strap_code = '0;
  logic [CW-1:0] sel_code;
  logic sys_rst_n;
  logic [CW-1:0] cfg_code;
  logic cfg_wd_en;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  wdt_freq_recovery #(.CODE_W(CW), .TIMEOUT_TICKS(T), .PULSE_TICKS(P)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .svc(svc),
    .cfg_code_we(cfg_code_we), .cfg_code_d(cfg_code_d),
    .cfg_en_we(cfg_en_we), .cfg_en_d(cfg_en_d),
    .fb_code(fb_code), .strap_code(strap_code),
    .sel_code(sel_code), .sys_rst_n(sys_rst_n),
    .cfg_code(cfg_code), .cfg_wd_en(cfg_wd_en)
  );

  // each entry: {software code, fall-back code, strap code}
  localparam logic [14:0] VEC [0:2] = '{
    {5'd3,  5'd17, 5'd9},
    {5'd28, 5'd6,  5'd21},
    {5'd11, 5'd30, 5'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr_code(input logic [CW-1:0] c);
    cfg_code_we = 1'b1; cfg_code_d = c;
    cyc(1);
    cfg_code_we = 1'b0;
  endtask

  task automatic wr_en(input logic e);
    cfg_en_we = 1'b1; cfg_en_d = e;
    cyc(1);
    cfg_en_we = 1'b0;
  endtask

  task automatic service();
    svc = 1'b1;
    cyc(1);
    svc = 1'b0;
  endtask

  // called right after the edge that enabled or serviced the watchdog
  task automatic run_timeout(input logic [CW-1:0] pre, input logic [CW-1:0] post, input string req);
    int n = 0;
    int m = 1;
    bit held = 1;
    while (sys_rst_n && n < 4 * T) begin
      cyc(1);
      n++;
      if (n == 3) chk(sel_code == pre, {req, " R8 code before timeout"}, sel_code, pre);
    end
    chk(n == T, "R2 cycles to timeout", n, T);
    while (m < 4 * P) begin
      cyc(1);
      if (sys_rst_n) break;
      m++;
      if (sel_code != pre) held = 0;
    end
    chk(m == P, "R2 pulse width", m, P);
    chk(held, "R7 code held during pulse", held, 1);
    chk(sel_code == post, {req, " R7 code at pulse end"}, sel_code, post);
    chk(cfg_code == fb_code && cfg_wd_en == 1'b0, {req, " copy fall-back and clear enable"},
        {cfg_wd_en, cfg_code}, {1'b0, fb_code});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    strap_code = 5'd21;
    fb_code = 5'd14;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    chk(sel_code == 5'd21, "R1 sel follows strap", sel_code, 21);
    chk(sys_rst_n == 1'b1, "R1 reset output high", sys_rst_n, 1);
    chk(cfg_wd_en == 1'b0 && cfg_code == '0, "R1 config cleared", {cfg_wd_en, cfg_code}, 0);

    // R4 disabled watchdog never fires
    begin
      bit low = 0;
      for (int i = 0; i < 3 * T; i++) begin
        cyc(1);
        if (!sys_rst_n) low = 1;
      end
      chk(!low, "R4 no pulse while disabled", low, 0);
    end

    // vector walk: full escalation ladder per entry
    for (int v = 0; v < 3; v++) begin
      logic [CW-1:0] sw, fb, st;
      {sw, fb, st} = VEC[v];
      fb_code = fb;
      strap_code = st;
      wr_code(sw);
      wr_en(1'b1);
      run_timeout(sw, fb, "R5");
      wr_en(1'b1);            // enable only: stays on fall-back (R8)
      run_timeout(fb, st, "R6");
      wr_en(1'b1);
      run_timeout(st, st, "R11");
    end

    // R3 service keeps the block quiet, then reload measured exactly
    begin
      bit low = 0;
      fb_code = 5'd19;
      wr_code(5'd7);
      wr_en(1'b1);
      for (int k = 0; k < 6; k++) begin
        cyc(T - 3);
        if (!sys_rst_n) low = 1;
        service();
        if (!sys_rst_n) low = 1;
      end
      chk(!low, "R3 no pulse while serviced", low, 0);
      chk(sel_code == 5'd7, "R3 code unchanged by service", sel_code, 7);
      run_timeout(5'd7, 5'd19, "R3");
    end

    // R10 ticks gate the count
    begin
      bit low = 0;
      wr_code(5'd9);
      wr_en(1'b1);
      tick = 1'b0;
      for (int i = 0; i < 4 * T; i++) begin
        cyc(1);
        if (!sys_rst_n) low = 1;
      end
      chk(!low, "R10 no pulse without ticks", low, 0);
      tick = 1'b1;
      run_timeout(5'd9, 5'd19, "R10");
    end

    // R9 writes during pulse ignored
    begin
      int w = 0;
      wr_code(5'd12);
      wr_en(1'b1);
      while (sys_rst_n && w < 4 * T) begin
        cyc(1);
        w++;
      end
      wr_code(5'd30);
      wr_en(1'b1);
      w = 0;
      while (!sys_rst_n && w < 4 * P) begin
        cyc(1);
        w++;
      end
      chk(cfg_code == 5'd19, "R9 code write in pulse ignored", cfg_code, 19);
      chk(cfg_wd_en == 1'b0, "R9 enable write in pulse ignored", cfg_wd_en, 0);
      chk(sel_code == 5'd19, "R9 source stays fall-back", sel_code, 19);
    end

    // R8 rewrite then enable returns to software code
    wr_code(5'd4);
    cyc(2);
    chk(sel_code == 5'd19, "R8 code write alone keeps fall-back", sel_code, 19);
    wr_en(1'b1);
    cyc(2);
    chk(sel_code == 5'd4, "R8 rewrite plus enable restores software code", sel_code, 4);
    wr_en(1'b0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule